// File: doc/BRIEF.md
# Rule-Table Turing Machine Engine

This block is a small programmable Turing machine. A table of rules, indexed by the pair (present state, symbol under the head), is loaded over a write port while the engine is idle. Each rule gives an operation, a symbol to write and the next state. The tape is a bounded array of symbol cells with a head pointer. Blank is symbol code 00.

A start pulse clears the tape to blank, puts the machine in state 0 with the head on cell 0, and zeroes the step counter. From then on the engine takes one step per clock. In each step it looks up the rule for its state and the symbol under the head, then applies that rule. The run ends in one of three ways: the machine halts, it faults (no usable rule, or a move off the tape), or it reaches the step limit given on an input. A read-only peek port returns any tape cell at any time, so the result can be read out.

Top module: `tm_engine`

## Requirements
- R1: After reset: busy, halted, error and timeout are low, the step count is 0 and every tape cell reads blank (00).
- R2: While idle, a pulse on the rule write port stores (valid, operation, write symbol, next state) at index (state, symbol). Only entries with the valid bit set can be matched.
- R3: A start pulse sets busy, clears halted/error/timeout and the step count, puts the state at 0 and the head at cell 0, and clears every tape cell to blank.
- R4: Each busy cycle that is not a fault executes one rule and adds 1 to the step count. The operation codes are: 0 writes the rule symbol at the head; 1 moves the head right; 2 moves the head left; 3 halts; 4 writes the symbol and then moves right. The state becomes the rule's next state.
- R5: Operation 3 sets halted, clears busy and counts as a step.
- R6: If the matched entry is invalid, or its operation code is 5 to 7, the engine sets error and clears busy. The tape and the step count stay unchanged.
- R7: A left move from cell 0, or a right move (including operation 4) from the last cell, sets error and clears busy. It writes nothing and does not count as a step.
- R8: When the step count equals the limit input at the start of a busy cycle, the engine sets timeout and clears busy. A limit of 0 therefore runs no step at all.
- R9: Rule writes that arrive while busy are dropped; later runs behave as if they never happened.
- R10: The peek output shows the tape cell at the peek address combinationally.
- R11: The rules (S0,blank: write 0 (code 01) then right to S1), (S1,blank: right to S2), (S2,blank: write 1 (code 10) then right to S3), (S3,blank: right to S0) with a limit of 16 leave the pattern 0,b,1,b on cells 0 to 15. All higher cells stay blank.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: begins a run from a clean state |
| limit_i | input | STEP_W | Maximum number of steps for the run |
| rule_we_i | input | 1 | Rule table write strobe |
| rule_state_i | input | STATE_W | State part of the rule index |
| rule_sym_i | input | SYM_W | Symbol part of the rule index |
| rule_valid_i | input | 1 | Valid bit stored with the rule |
| rule_op_i | input | 3 | Operation code stored with the rule |
| rule_wsym_i | input | SYM_W | Symbol written by write operations |
| rule_next_i | input | STATE_W | Next state after the rule executes |
| peek_addr_i | input | HEAD_W | Tape cell to read out |
| peek_sym_o | output | SYM_W | Symbol stored in the peeked cell |
| busy_o | output | 1 | Run in progress |
| halted_o | output | 1 | Run ended on a halt rule |
| err_o | output | 1 | Run ended on a fault (no usable rule or off-tape move) |
| timeout_o | output | 1 | Run ended by the step limit |
| steps_o | output | STEP_W | Steps executed in the current or last run |

## Verification
The assertions assume that the limit input holds its value while a run is in progress, because the bound on the step count is checked against the live input. The bench changes the limit only between runs. Rule writes are deliberately issued during a run, to exercise the write-drop path, but the tape, rule table and peek address are otherwise driven only while idle or checked against a reference model that tracks every edge. Start pulses last a single cycle and are never sent while busy.

// File: rtl/tm_pkg.sv
package tm_pkg;
   // operation encodings stored in each rule
   typedef enum logic [2:0] {
      OP_WRITE       = 3'd0,
      OP_RIGHT       = 3'd1,
      OP_LEFT        = 3'd2,
      OP_HALT        = 3'd3,
      OP_WRITE_RIGHT = 3'd4
   } tm_op_e;

   localparam int OP_W = 3;
endpackage

// File: rtl/tm_rule_table.sv
module tm_rule_table
   import tm_pkg::*;
#(
   parameter int STATE_W = 3,
   parameter int SYM_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy_i,
   input  logic               we_i,
   input  logic [STATE_W-1:0] wr_state_i,
   input  logic [SYM_W-1:0]   wr_sym_i,
   input  logic               wr_valid_i,
   input  logic [OP_W-1:0]    wr_op_i,
   input  logic [SYM_W-1:0]   wr_wsym_i,
   input  logic [STATE_W-1:0] wr_next_i,
   input  logic [STATE_W-1:0] rd_state_i,
   input  logic [SYM_W-1:0]   rd_sym_i,
   output logic               rd_valid_o,
   output logic [OP_W-1:0]    rd_op_o,
   output logic [SYM_W-1:0]   rd_wsym_o,
   output logic [STATE_W-1:0] rd_next_o
);
   localparam int IDX_W   = STATE_W + SYM_W;
   localparam int ENTRIES = 1 << IDX_W;
   localparam int ENTRY_W = 1 + OP_W + SYM_W + STATE_W;

   if (IDX_W > 10) begin : g_too_big
      $error("rule table index too wide");
   end

   logic [ENTRIES-1:0][ENTRY_W-1:0] table_q;
   logic [IDX_W-1:0]                wr_idx;
   logic [IDX_W-1:0]                rd_idx;
   logic                            accept;
   logic [ENTRY_W-1:0]              rd_entry;

   assign wr_idx = {wr_state_i, wr_sym_i};
   assign rd_idx = {rd_state_i, rd_sym_i};
   assign accept = we_i && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         table_q <= '0;
      end else if (accept) begin
         table_q[wr_idx] <= {wr_valid_i, wr_op_i, wr_wsym_i, wr_next_i};
      end
   end

   assign rd_entry = table_q[rd_idx];
   assign {rd_valid_o, rd_op_o, rd_wsym_o, rd_next_o} = rd_entry;

   // R9
   table_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i) |-> $stable(table_q));
endmodule

// File: rtl/tm_tape.sv
module tm_tape #(
   parameter int SYM_W          = 2,
   parameter int TAPE_LEN       = 64,
   parameter bit CLEAR_ON_START = 1'b1,
   localparam int HEAD_W        = $clog2(TAPE_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [HEAD_W-1:0] head_i,
   input  logic [SYM_W-1:0]  wsym_i,
   output logic [SYM_W-1:0]  head_sym_o,
   input  logic [HEAD_W-1:0] peek_addr_i,
   output logic [SYM_W-1:0]  peek_sym_o
);
   if ((1 << HEAD_W) != TAPE_LEN) begin : g_len_chk
      $error("tape length must be a power of two");
   end

   logic [SYM_W-1:0]    cells [TAPE_LEN];
   logic [TAPE_LEN-1:0] we_hit;
   logic                clr_hit;

   if (CLEAR_ON_START) begin : g_clear
      assign clr_hit = clr_i;
   end else begin : g_keep
      assign clr_hit = 1'b0;
   end

   for (genvar i = 0; i < TAPE_LEN; i++) begin : g_dec
      assign we_hit[i] = we_i && (head_i == HEAD_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPE_LEN; i++) cells[i] <= '0;
      end else begin
         for (int i = 0; i < TAPE_LEN; i++) begin
            if (clr_hit)        cells[i] <= '0;
            else if (we_hit[i]) cells[i] <= wsym_i;
         end
      end
   end

   assign head_sym_o = cells[head_i];
   assign peek_sym_o = cells[peek_addr_i];

   // R3
   tape_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && CLEAR_ON_START) |=> (head_sym_o == '0));
endmodule

// File: rtl/tm_control.sv
module tm_control
   import tm_pkg::*;
#(
   parameter int STATE_W  = 3,
   parameter int SYM_W    = 2,
   parameter int TAPE_LEN = 64,
   parameter int STEP_W   = 16,
   localparam int HEAD_W  = $clog2(TAPE_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [STEP_W-1:0]  limit_i,
   input  logic               rule_valid_i,
   input  logic [OP_W-1:0]    rule_op_i,
   input  logic [SYM_W-1:0]   rule_wsym_i,
   input  logic [STATE_W-1:0] rule_next_i,
   output logic [STATE_W-1:0] state_o,
   output logic [HEAD_W-1:0]  head_o,
   output logic               tape_we_o,
   output logic [SYM_W-1:0]   tape_wsym_o,
   output logic               tape_clr_o,
   output logic               busy_o,
   output logic               halted_o,
   output logic               err_o,
   output logic               timeout_o,
   output logic [STEP_W-1:0]  steps_o
);
   localparam logic [HEAD_W-1:0] LAST_CELL = HEAD_W'(TAPE_LEN - 1);

   logic [STATE_W-1:0] state_q, state_d;
   logic [HEAD_W-1:0]  head_q, head_d;
   logic [STEP_W-1:0]  steps_q, steps_d;
   logic               busy_q, busy_d;
   logic               halt_q, halt_d;
   logic               err_q, err_d;
   logic               to_q, to_d;
   logic               at_left, at_right;

   assign at_left  = (head_q == '0);
   assign at_right = (head_q == LAST_CELL);

   always_comb begin
      state_d     = state_q;
      head_d      = head_q;
      steps_d     = steps_q;
      busy_d      = busy_q;
      halt_d      = halt_q;
      err_d       = err_q;
      to_d        = to_q;
      tape_we_o   = 1'b0;
      tape_clr_o  = 1'b0;
      tape_wsym_o = rule_wsym_i;
      if (start_i) begin
         state_d    = '0;
         head_d     = '0;
         steps_d    = '0;
         busy_d     = 1'b1;
         halt_d     = 1'b0;
         err_d      = 1'b0;
         to_d       = 1'b0;
         tape_clr_o = 1'b1;
      end else if (busy_q) begin
         if (steps_q >= limit_i) begin
            to_d   = 1'b1;
            busy_d = 1'b0;
         end else if (!rule_valid_i) begin
            err_d  = 1'b1;
            busy_d = 1'b0;
         end else begin
            case (rule_op_i)
               OP_WRITE: begin
                  tape_we_o = 1'b1;
                  state_d   = rule_next_i;
                  steps_d   = steps_q + STEP_W'(1);
               end
               OP_RIGHT, OP_WRITE_RIGHT: begin
                  if (at_right) begin
                     err_d  = 1'b1;
                     busy_d = 1'b0;
                  end else begin
                     tape_we_o = (rule_op_i == OP_WRITE_RIGHT);
                     head_d    = head_q + HEAD_W'(1);
                     state_d   = rule_next_i;
                     steps_d   = steps_q + STEP_W'(1);
                  end
               end
               OP_LEFT: begin
                  if (at_left) begin
                     err_d  = 1'b1;
                     busy_d = 1'b0;
                  end else begin
                     head_d  = head_q - HEAD_W'(1);
                     state_d = rule_next_i;
                     steps_d = steps_q + STEP_W'(1);
                  end
               end
               OP_HALT: begin
                  halt_d  = 1'b1;
                  busy_d  = 1'b0;
                  steps_d = steps_q + STEP_W'(1);
               end
               default: begin
                  err_d  = 1'b1;
                  busy_d = 1'b0;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         head_q  <= '0;
         steps_q <= '0;
         busy_q  <= 1'b0;
         halt_q  <= 1'b0;
         err_q   <= 1'b0;
         to_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         head_q  <= head_d;
         steps_q <= steps_d;
         busy_q  <= busy_d;
         halt_q  <= halt_d;
         err_q   <= err_d;
         to_q    <= to_d;
      end
   end

   assign state_o   = state_q;
   assign head_o    = head_q;
   assign busy_o    = busy_q;
   assign halted_o  = halt_q;
   assign err_o     = err_q;
   assign timeout_o = to_q;
   assign steps_o   = steps_q;

   // R3
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_o && steps_o == '0 && head_o == '0 && state_o == '0
                   && !halted_o && !err_o && !timeout_o));
   // R5
   halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> !busy_o);
   // R6
   end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({halted_o, err_o, timeout_o}));
   // R4
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> (steps_o == $past(steps_o) || steps_o == $past(steps_o) + STEP_W'(1)));
   // R8
   limit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (steps_o <= limit_i));
   // R7
   edge_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i && at_left && rule_valid_i && rule_op_i == OP_LEFT
       && steps_o < limit_i) |=> (err_o && $stable(head_o)));
endmodule

// File: rtl/tm_engine.sv
module tm_engine
   import tm_pkg::*;
#(
   parameter int STATE_W        = 3,
   parameter int SYM_W          = 2,
   parameter int TAPE_LEN       = 64,
   parameter int STEP_W         = 16,
   parameter bit CLEAR_ON_START = 1'b1,
   localparam int HEAD_W        = $clog2(TAPE_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [STEP_W-1:0]  limit_i,
   input  logic               rule_we_i,
   input  logic [STATE_W-1:0] rule_state_i,
   input  logic [SYM_W-1:0]   rule_sym_i,
   input  logic               rule_valid_i,
   input  logic [2:0]         rule_op_i,
   input  logic [SYM_W-1:0]   rule_wsym_i,
   input  logic [STATE_W-1:0] rule_next_i,
   input  logic [HEAD_W-1:0]  peek_addr_i,
   output logic [SYM_W-1:0]   peek_sym_o,
   output logic               busy_o,
   output logic               halted_o,
   output logic               err_o,
   output logic               timeout_o,
   output logic [STEP_W-1:0]  steps_o
);
   if (SYM_W < 2)    begin : g_sym_chk   $error("alphabet needs at least two bits"); end
   if (STATE_W < 1)  begin : g_state_chk $error("need at least one state bit"); end
   if (TAPE_LEN < 2) begin : g_tape_chk  $error("tape too short"); end
   if (STEP_W < 1)   begin : g_step_chk  $error("step counter width"); end

   logic [STATE_W-1:0] cur_state;
   logic [HEAD_W-1:0]  head;
   logic [SYM_W-1:0]   head_sym;
   logic               r_valid;
   logic [OP_W-1:0]    r_op;
   logic [SYM_W-1:0]   r_wsym;
   logic [STATE_W-1:0] r_next;
   logic               t_we, t_clr;
   logic [SYM_W-1:0]   t_wsym;

   tm_rule_table #(.STATE_W(STATE_W), .SYM_W(SYM_W)) i_rules (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_o),
      .we_i       (rule_we_i),
      .wr_state_i (rule_state_i),
      .wr_sym_i   (rule_sym_i),
      .wr_valid_i (rule_valid_i),
      .wr_op_i    (rule_op_i),
      .wr_wsym_i  (rule_wsym_i),
      .wr_next_i  (rule_next_i),
      .rd_state_i (cur_state),
      .rd_sym_i   (head_sym),
      .rd_valid_o (r_valid),
      .rd_op_o    (r_op),
      .rd_wsym_o  (r_wsym),
      .rd_next_o  (r_next)
   );

   tm_tape #(.SYM_W(SYM_W), .TAPE_LEN(TAPE_LEN), .CLEAR_ON_START(CLEAR_ON_START)) i_tape (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (t_clr),
      .we_i        (t_we),
      .head_i      (head),
      .wsym_i      (t_wsym),
      .head_sym_o  (head_sym),
      .peek_addr_i (peek_addr_i),
      .peek_sym_o  (peek_sym_o)
   );

   tm_control #(.STATE_W(STATE_W), .SYM_W(SYM_W), .TAPE_LEN(TAPE_LEN), .STEP_W(STEP_W)) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .limit_i      (limit_i),
      .rule_valid_i (r_valid),
      .rule_op_i    (r_op),
      .rule_wsym_i  (r_wsym),
      .rule_next_i  (r_next),
      .state_o      (cur_state),
      .head_o       (head),
      .tape_we_o    (t_we),
      .tape_wsym_o  (t_wsym),
      .tape_clr_o   (t_clr),
      .busy_o       (busy_o),
      .halted_o     (halted_o),
      .err_o        (err_o),
      .timeout_o    (timeout_o),
      .steps_o      (steps_o)
   );

   // R6
   invalid_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i && !r_valid && steps_o < limit_i) |=> (err_o && !busy_o && $stable(steps_o)));
endmodule

// File: tb/test_tm_engine.sv
module test_tm_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NCELL      = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] limit_i = '0;
   logic        rule_we_i = 1'b0;
   logic [2:0]  rule_state_i = '0;
   logic [1:0]  rule_sym_i = '0;
   logic        rule_valid_i = 1'b0;
   logic [2:0]  rule_op_i = '0;
   logic [1:0]  rule_wsym_i = '0;
   logic [2:0]  rule_next_i = '0;
   logic [5:0]  peek_addr_i = '0;
   logic [1:0]  peek_sym_o;
   logic        busy_o, halted_o, err_o, timeout_o;
   logic [15:0] steps_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   tm_engine i_tm_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .limit_i(limit_i),
      .rule_we_i(rule_we_i), .rule_state_i(rule_state_i), .rule_sym_i(rule_sym_i),
      .rule_valid_i(rule_valid_i), .rule_op_i(rule_op_i), .rule_wsym_i(rule_wsym_i),
      .rule_next_i(rule_next_i), .peek_addr_i(peek_addr_i), .peek_sym_o(peek_sym_o),
      .busy_o(busy_o), .halted_o(halted_o), .err_o(err_o), .timeout_o(timeout_o),
      .steps_o(steps_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_valid [32];
   int m_op    [32];
   int m_wsym  [32];
   int m_next  [32];
   int m_tape  [NCELL];
   int m_state, m_head, m_steps, m_busy, m_halt, m_err, m_to, m_idx;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) m_valid[i] = 0;
         for (int i = 0; i < NCELL; i++) m_tape[i] = 0;
         m_state = 0; m_head = 0; m_steps = 0;
         m_busy = 0; m_halt = 0; m_err = 0; m_to = 0;
      end else begin
         if (start_i) begin
            for (int i = 0; i < NCELL; i++) m_tape[i] = 0;
            m_state = 0; m_head = 0; m_steps = 0;
            m_busy = 1; m_halt = 0; m_err = 0; m_to = 0;
            if (rule_we_i) begin
               m_idx = rule_state_i * 4 + rule_sym_i;
               m_valid[m_idx] = rule_valid_i; m_op[m_idx] = rule_op_i;
               m_wsym[m_idx] = rule_wsym_i;   m_next[m_idx] = rule_next_i;
            end
         end else if (m_busy != 0) begin
            m_idx = m_state * 4 + m_tape[m_head];
            if (m_steps >= int'(limit_i)) begin m_to = 1; m_busy = 0; end
            else if (m_valid[m_idx] == 0) begin m_err = 1; m_busy = 0; end
            else if (m_op[m_idx] == 0) begin
               m_tape[m_head] = m_wsym[m_idx]; m_state = m_next[m_idx]; m_steps++;
            end else if (m_op[m_idx] == 1 || m_op[m_idx] == 4) begin
               if (m_head == NCELL - 1) begin m_err = 1; m_busy = 0; end
               else begin
                  if (m_op[m_idx] == 4) m_tape[m_head] = m_wsym[m_idx];
                  m_head++; m_state = m_next[m_idx]; m_steps++;
               end
            end else if (m_op[m_idx] == 2) begin
               if (m_head == 0) begin m_err = 1; m_busy = 0; end
               else begin m_head--; m_state = m_next[m_idx]; m_steps++; end
            end else if (m_op[m_idx] == 3) begin
               m_halt = 1; m_busy = 0; m_steps++;
            end else begin
               m_err = 1; m_busy = 0;
            end
         end else if (rule_we_i) begin
            m_idx = rule_state_i * 4 + rule_sym_i;
            m_valid[m_idx] = rule_valid_i; m_op[m_idx] = rule_op_i;
            m_wsym[m_idx] = rule_wsym_i;   m_next[m_idx] = rule_next_i;
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 busy", int'(busy_o), m_busy);
         chk("R5 halted", int'(halted_o), m_halt);
         chk("R6 error", int'(err_o), m_err);
         chk("R8 timeout", int'(timeout_o), m_to);
         chk("R4 steps", int'(steps_o), m_steps);
         chk("R10 peek", int'(peek_sym_o), m_tape[peek_addr_i]);
      end
   end

   task automatic wr_rule(int st, int sy, int vld, int op, int ws, int nx);
      @(posedge clk); #2;
      rule_we_i = 1'b1; rule_state_i = 3'(st); rule_sym_i = 2'(sy);
      rule_valid_i = 1'(vld); rule_op_i = 3'(op); rule_wsym_i = 2'(ws); rule_next_i = 3'(nx);
      @(posedge clk); #2;
      rule_we_i = 1'b0;
   endtask

   task automatic run(int lim);
      @(posedge clk); #2;
      limit_i = 16'(lim); start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      while (busy_o) begin @(posedge clk); #2; end
   endtask

   task automatic peek(int addr, string tag, int exp);
      @(posedge clk); #2;
      peek_addr_i = 6'(addr);
      #1;
      chk(tag, int'(peek_sym_o), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 flags", int'({halted_o, err_o, timeout_o}), 0);
      chk("R1 steps", int'(steps_o), 0);
      for (int a = 0; a < NCELL; a++) peek(a, "R1 blank tape", 0);

      // R2 / R11 pattern program, with R9 drop during the run
      wr_rule(0, 0, 1, 4, 1, 1);
      wr_rule(1, 0, 1, 1, 0, 2);
      wr_rule(2, 0, 1, 4, 2, 3);
      wr_rule(3, 0, 1, 1, 0, 0);
      @(posedge clk); #2;
      limit_i = 16'd16; start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      @(posedge clk); #2;
      rule_we_i = 1'b1; rule_state_i = 3'd0; rule_sym_i = 2'd0;
      rule_valid_i = 1'b1; rule_op_i = 3'd3; rule_wsym_i = 2'd0; rule_next_i = 3'd0;
      @(posedge clk); #2;
      rule_we_i = 1'b0;
      while (busy_o) begin @(posedge clk); #2; end
      chk("R8 timeout after limit", int'(timeout_o), 1);
      chk("R11 steps", int'(steps_o), 16);
      for (int a = 0; a < 20; a++)
         peek(a, "R11 pattern", (a >= 16) ? 0 : ((a % 4 == 0) ? 1 : ((a % 4 == 2) ? 2 : 0)));

      // R9: rerun must produce the same pattern
      run(16);
      chk("R9 ignored write steps", int'(steps_o), 16);
      peek(0, "R9 ignored write cell0", 1);
      peek(2, "R9 ignored write cell2", 2);

      // R5 halting program, also write and left moves (R4)
      wr_rule(0, 0, 1, 0, 2, 1);
      wr_rule(1, 2, 1, 1, 0, 2);
      wr_rule(2, 0, 1, 2, 0, 3);
      wr_rule(3, 2, 1, 3, 0, 3);
      run(100);
      chk("R5 halted", int'(halted_o), 1);
      chk("R5 steps incl halt", int'(steps_o), 4);
      peek(0, "R4 write cell0", 2);
      peek(1, "R3 cleared cell1", 0);

      // R6 missing rule then invalid opcode
      wr_rule(0, 0, 1, 0, 2, 5);
      run(100);
      chk("R6 no rule error", int'(err_o), 1);
      chk("R6 no rule steps", int'(steps_o), 1);
      wr_rule(5, 2, 1, 6, 0, 0);
      run(100);
      chk("R6 bad op error", int'(err_o), 1);
      chk("R6 bad op steps", int'(steps_o), 1);
      peek(0, "R6 tape kept", 2);

      // R7 left edge
      wr_rule(0, 0, 1, 2, 0, 0);
      run(100);
      chk("R7 left edge error", int'(err_o), 1);
      chk("R7 left edge steps", int'(steps_o), 0);
      peek(0, "R7 left edge tape", 0);

      // R7 right edge with write-and-move
      wr_rule(0, 0, 1, 4, 1, 0);
      run(200);
      chk("R7 right edge error", int'(err_o), 1);
      chk("R7 right edge steps", int'(steps_o), 63);
      peek(62, "R7 cell 62", 1);
      peek(63, "R7 last cell unwritten", 0);

      // R8 zero limit
      run(0);
      chk("R8 zero limit timeout", int'(timeout_o), 1);
      chk("R8 zero limit steps", int'(steps_o), 0);
      peek(0, "R8 zero limit tape", 0);

      repeat (2) @(posedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule